// File: doc/BRIEF.md
# Two-Node Write-Update Coherent Store

This block holds one shared store of small words for two processors. Each processor has its own full copy of the store, and no memory sits behind the copies. A read is served from the local copy and never misses. A write is made atomic by a single shared bus. The writer must win the bus, push the new address and data to the peer copy, and wait until the peer confirms that it has applied the value. Only then does the writer update its own copy and give the bus back.

Each processor talks to the block through a valid/ready request port. A write holds `req_ready` low for the whole round trip, so the writing processor stalls and every write is serialized against every other write. Reads by the other processor carry on during that time. Such a read returns the old value until the peer copy has been updated, and the new value from then on. When both processors ask for the bus in the same cycle, a round-robin choice decides which one goes first.

Top module: `dual_update_store`

## Requirements
- R1: After reset every one of the 16 entries (4-bit address, 8-bit data) reads as zero from both nodes.
- R2: A read is accepted in any cycle where its node has no write in progress. Node n uses request slot n: bits [n], address [4n+3:4n], data [8n+7:8n]. `rd_valid[n]` is high, and `rd_data` holds the local entry, in the cycle after acceptance.
- R3: An uncontested write is accepted in the third cycle of its request. `req_ready` for that node is low in the first two cycles.
- R4: Once a write is accepted, reads from both nodes return the new value.
- R5: A peer read accepted in the first or second cycle of a write returns the old value. One accepted in the third cycle returns the new value. The writer's own copy changes only after the peer has acknowledged.
- R6: At most one node has a write in progress at any time, and a bus release only happens while the bus is held.
- R7: The peer copy acknowledges an update exactly one cycle after receiving it.
- R8: When both nodes request the bus in the same cycle, the node not granted most recently wins; node 0 wins first after reset. The winner is accepted in cycle 3 and the loser in cycle 6.
- R9: When both nodes write the same address together, both copies end up holding the data of the node granted second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 2 | Request present, one bit per node |
| req_write | input | 2 | 1 = write, 0 = read, per node |
| req_addr | input | 8 | Entry address, 4 bits per node |
| req_wdata | input | 16 | Write data, 8 bits per node |
| req_ready | output | 2 | Request accepted at the next edge, per node |
| rd_valid | output | 2 | Read data present, per node |
| rd_data | output | 16 | Read data, 8 bits per node |

## Verification
The hardest case to reach is a peer read that lands exactly in the window between the peer copy taking an update and the writer committing its own copy. Only then does the split between old and new values show. The bench starts a write on one node and a read on the other from the same falling edge, with offsets of zero, one and two cycles, and checks old, old, new. Same-cycle write pairs are placed after a solo write by either node so that both arbitration outcomes occur, including pairs that collide on one address. Randomized single operations and pairs are then checked against a model that orders the pair by the bench's own round-robin record.

// File: rtl/dus_pkg.sv
package dus_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int NODES  = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_UPD, ST_WAIT} wr_state_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } upd_msg_t;

  // round-robin: the node just granted yields priority to the other
  function automatic logic next_prio(input logic granted_idx);
    return ~granted_idx;
  endfunction

  // pick the winner among two requesters given the priority node
  function automatic logic [1:0] rr_pick(input logic [1:0] req, input logic prio);
    if (req == 2'b11) return prio ? 2'b10 : 2'b01;
    return req;
  endfunction
endpackage

// File: rtl/dus_arbiter.sv
module dus_arbiter
  import dus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_req,
  input  logic [1:0] release_i,
  output logic [1:0] grant,
  output logic       busy
);
  logic prio_q;
  logic busy_q;

  assign busy  = busy_q;
  assign grant = busy_q ? 2'b00 : rr_pick(bus_req, prio_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      prio_q <= 1'b0;
    end else begin
      if (grant != 2'b00) begin
        busy_q <= 1'b1;
        prio_q <= next_prio(grant[1]);
      end else if (release_i != 2'b00) begin
        busy_q <= 1'b0;
      end
    end
  end

  // R6
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
  // R6
  release_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i != 2'b00) |-> busy_q);
endmodule

// File: rtl/dus_cache.sv
module dus_cache
  import dus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              loc_we,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic [DATA_W-1:0] loc_data,
  input  logic              upd_valid,
  input  upd_msg_t          upd_msg,
  output logic              ack_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      ack_o    <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= mem[rd_addr];
      if (upd_valid)   mem[upd_msg.addr] <= upd_msg.data;
      else if (loc_we) mem[loc_addr]     <= loc_data;
      ack_o <= upd_valid;
    end
  end

  // R6
  no_dual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && loc_we));
endmodule

// File: rtl/dus_node.sv
module dus_node
  import dus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic              grant,
  input  logic              ack_i,
  output logic              bus_req,
  output logic              upd_valid,
  output upd_msg_t          upd_msg,
  output logic              rd_en,
  output logic              loc_we,
  output logic [ADDR_W-1:0] loc_addr,
  output logic [DATA_W-1:0] loc_data,
  output logic              release_o,
  output logic              active
);
  wr_state_t state_q;
  upd_msg_t  msg_q;

  assign active    = (state_q != ST_IDLE);
  assign bus_req   = (state_q == ST_IDLE) && req_valid && req_write;
  assign upd_valid = (state_q == ST_UPD);
  assign upd_msg   = msg_q;
  assign loc_we    = (state_q == ST_WAIT) && ack_i;
  assign loc_addr  = msg_q.addr;
  assign loc_data  = msg_q.data;
  assign release_o = loc_we;
  assign rd_en     = (state_q == ST_IDLE) && req_valid && !req_write;
  assign req_ready = ((state_q == ST_IDLE) && !req_write) || loc_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      msg_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (bus_req && grant) begin
          state_q <= ST_UPD;
          msg_q   <= '{addr: req_addr, data: req_wdata};
        end
        ST_UPD:  state_q <= ST_WAIT;
        ST_WAIT: if (ack_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  upd_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_valid) |-> $past(grant));
  // R5
  commit_after_peer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_we |-> $past(upd_valid));
  // R3
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> !req_ready);
endmodule

// File: rtl/dual_update_store.sv
module dual_update_store
  import dus_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NODES-1:0]         req_valid,
  input  logic [NODES-1:0]         req_write,
  input  logic [NODES*ADDR_W-1:0]  req_addr,
  input  logic [NODES*DATA_W-1:0]  req_wdata,
  output logic [NODES-1:0]         req_ready,
  output logic [NODES-1:0]         rd_valid,
  output logic [NODES*DATA_W-1:0]  rd_data
);
  logic [1:0] bus_req, grant, rel, upd_valid, cache_ack, node_active, rd_en, loc_we;
  logic       bus_busy;
  upd_msg_t   upd_msg [NODES];
  logic [ADDR_W-1:0] loc_addr [NODES];
  logic [DATA_W-1:0] loc_data [NODES];

  dus_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .release_i(rel),
    .grant(grant), .busy(bus_busy)
  );

  for (genvar g = 0; g < NODES; g++) begin : g_node
    localparam int PEER = 1 - g;

    dus_node u_node (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid[g]), .req_write(req_write[g]),
      .req_addr(req_addr[g*ADDR_W +: ADDR_W]),
      .req_wdata(req_wdata[g*DATA_W +: DATA_W]),
      .req_ready(req_ready[g]),
      .grant(grant[g]), .ack_i(cache_ack[PEER]),
      .bus_req(bus_req[g]), .upd_valid(upd_valid[g]), .upd_msg(upd_msg[g]),
      .rd_en(rd_en[g]), .loc_we(loc_we[g]),
      .loc_addr(loc_addr[g]), .loc_data(loc_data[g]),
      .release_o(rel[g]), .active(node_active[g])
    );

    dus_cache u_cache (
      .clk(clk), .rst_n(rst_n),
      .rd_en(rd_en[g]), .rd_addr(req_addr[g*ADDR_W +: ADDR_W]),
      .rd_valid(rd_valid[g]), .rd_data(rd_data[g*DATA_W +: DATA_W]),
      .loc_we(loc_we[g]), .loc_addr(loc_addr[g]), .loc_data(loc_data[g]),
      .upd_valid(upd_valid[PEER]), .upd_msg(upd_msg[PEER]),
      .ack_o(cache_ack[g])
    );

    // R7
    ack_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid[g] |=> cache_ack[PEER]);
  end

  // R6
  single_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(node_active) <= 1);
  // R6
  busy_covers_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (node_active != 2'b00) |-> bus_busy);
endmodule

// File: tb/dual_update_store_bench.sv
module dual_update_store_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  req_valid = '0, req_write = '0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_ready, rd_valid;
  logic [15:0] rd_data;

  int checks = 0, errors = 0;
  logic [7:0] mdl [16];
  int last_g = 1;

  always #2.5 clk = ~clk;

  dual_update_store u_dual_update_store (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int winner_of(input int last);
    return 1 - last;
  endfunction

  task automatic do_write(input int n, input logic [3:0] a, input logic [7:0] d, output int cyc);
    int c = 0;
    @(negedge clk);
    req_valid[n] = 1'b1; req_write[n] = 1'b1;
    req_addr[n*4 +: 4] = a; req_wdata[n*8 +: 8] = d;
    forever begin
      c++;
      #1;
      if (req_ready[n] || c > 20) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid[n] = 1'b0; req_write[n] = 1'b0;
    cyc = c;
  endtask

  task automatic do_read(input int n, input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    req_valid[n] = 1'b1; req_write[n] = 1'b0; req_addr[n*4 +: 4] = a;
    #1;
    chk("R2 read ready", int'(req_ready[n]), 1);
    @(posedge clk);
    @(negedge clk);
    req_valid[n] = 1'b0;
    #1;
    chk("R2 rd_valid", int'(rd_valid[n]), 1);
    d = rd_data[n*8 +: 8];
  endtask

  task automatic both_read(input logic [3:0] a, input int exp, input string tag);
    logic [7:0] d;
    for (int n = 0; n < 2; n++) begin
      do_read(n, a, d);
      chk(tag, int'(d), exp);
    end
  endtask

  task automatic solo_write(input int n, input logic [3:0] a, input logic [7:0] d);
    int c;
    do_write(n, a, d, c);
    chk("R3 solo write cycles", c, 3);
    mdl[a] = d;
    last_g = n;
  endtask

  task automatic pair_write(input logic [3:0] a0, input logic [7:0] d0,
                            input logic [3:0] a1, input logic [7:0] d1);
    int c0, c1, w;
    w = winner_of(last_g);
    fork
      do_write(0, a0, d0, c0);
      do_write(1, a1, d1, c1);
    join
    chk("R8 node0 cycles", c0, (w == 0) ? 3 : 6);
    chk("R8 node1 cycles", c1, (w == 1) ? 3 : 6);
    if (w == 0) begin mdl[a0] = d0; mdl[a1] = d1; last_g = 1; end
    else        begin mdl[a1] = d1; mdl[a0] = d0; last_g = 0; end
  endtask

  task automatic window_read(input int k, input logic [3:0] a, input logic [7:0] nv, input int exp);
    int c;
    logic [7:0] d;
    fork
      do_write(0, a, nv, c);
      begin
        repeat (k) @(negedge clk);
        do_read(1, a, d);
        chk("R5 peer read in write window", int'(d), exp);
      end
    join
    mdl[a] = nv;
    last_g = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int r;
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset contents
    for (int i = 0; i < 16; i++) both_read(4'(i), 0, "R1 reset zero");

    // R3 / R4 solo writes on both nodes
    solo_write(0, 4'd3, 8'hA5);
    both_read(4'd3, 8'hA5, "R4 after node0 write");
    solo_write(1, 4'd15, 8'hFF);
    both_read(4'd15, 8'hFF, "R4 after node1 write");

    // R5 peer read timing around a write of 0x11 -> 0x22 at addr 7
    solo_write(1, 4'd7, 8'h11);
    window_read(0, 4'd7, 8'h22, 8'h11);
    window_read(1, 4'd7, 8'h33, 8'h22);
    window_read(2, 4'd7, 8'h44, 8'h44);
    both_read(4'd7, 8'h44, "R4 after window writes");

    // R8 contention after a node1 solo write: node0 wins
    solo_write(1, 4'd0, 8'h01);
    pair_write(4'd1, 8'h10, 4'd2, 8'h20);
    both_read(4'd1, 8'h10, "R8 node0 data");
    both_read(4'd2, 8'h20, "R8 node1 data");
    // R8 contention after a node0 solo write: node1 wins
    solo_write(0, 4'd0, 8'h02);
    pair_write(4'd4, 8'h40, 4'd5, 8'h50);

    // R9 same address: later-granted data survives
    solo_write(0, 4'd9, 8'h00);
    pair_write(4'd9, 8'hC0, 4'd9, 8'hC1);
    both_read(4'd9, 8'hC0, "R9 same addr node0 second");
    solo_write(1, 4'd9, 8'h00);
    pair_write(4'd9, 8'hD0, 4'd9, 8'hD1);
    both_read(4'd9, 8'hD1, "R9 same addr node1 second");

    // random mix against the model
    for (int it = 0; it < 300; it++) begin
      r = int'($urandom % 3);
      if (r == 0) begin
        logic [3:0] a;
        int n;
        a = 4'($urandom); n = int'($urandom % 2);
        do_read(n, a, d);
        chk("R2 random read", int'(d), int'(mdl[a]));
      end else if (r == 1) begin
        solo_write(int'($urandom % 2), 4'($urandom), 8'($urandom));
      end else begin
        logic [3:0] a0, a1;
        a0 = 4'($urandom);
        a1 = ($urandom % 4 == 0) ? a0 : 4'($urandom);
        pair_write(a0, 8'($urandom), a1, 8'($urandom));
      end
    end
    for (int i = 0; i < 16; i++) both_read(4'(i), int'(mdl[i]), "R4 final sweep");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule